// File: doc/BRIEF.md
# ADC Conversion Instruction Sequencer

This block walks through a short program of up to eight conversion instructions held in an external instruction store, and drives the handshakes of a sample-and-hold and ADC controller for each one. For every instruction it reads the control field from the store, latches it, and presents the selected positive and negative multiplexer channel codes. It then asks the converter to acquire, optionally holds until an external trigger edge, and asks it to convert. When the conversion is done it moves on to the following instruction.

A host arms the sequencer with a soft reset, sets the run flag to start it and clears the run flag to stop it. Stopping always lets the instruction in progress complete. Two flags in each instruction change the flow. One ends the program early and sends the sequencer back to instruction 0. The other halts the sequencer before that instruction executes, drops the run flag and pulses an interrupt. The very first execution of instruction 0 after a soft reset does not honour its halt flag.

Top module: `conv_sequencer`

## Requirements
- R1: After hardware reset or a soft reset the sequencer reads instruction 0 (`instr_addr` = 0) and waits with `start_flag` = 0 and `busy` = 0, issuing no `acq_start`.
- R2: While `start_flag` is 1, each executed instruction produces exactly one single-cycle `acq_start` pulse. The first execution of instruction 0 after a soft reset ignores its pause flag (control bit 1) and raises no interrupt.
- R3: An instruction whose loop flag (control bit 0) is 1 is the last one; instruction 0 is read next.
- R4: After instruction 7 executes, instruction 0 is read next.
- R5: When an instruction with the pause flag (bit 1) is reached later, it is not executed, `start_flag` drops to 0 in the same cycle as a single-cycle `pause_irq` pulse, and setting the run flag again executes that same instruction without pausing a second time.
- R6: `pos_ch` shows control bits 4:2 and `neg_ch` shows bits 7:5 of the latched instruction, and `neg_gnd` is 1 exactly when `neg_ch` is 000 (ground, single-ended).
- R7: With the sync flag (bit 8) set, `conv_start` is withheld after `acq_done` until a rising edge on `sync_pin` reaches the two-flop synchronizer output. `conv_start` then pulses on the following clock. Without the flag, `conv_start` pulses on the clock after `acq_done`.
- R8: Clearing the run flag mid-instruction lets that instruction complete its conversion. The sequencer then stops at the next instruction with no further `acq_start`.
- R9: `busy` is 1 from the start of an execution until the sequencer is waiting for the run flag at an instruction boundary.
- R10: A rising edge on `sync_pin` that is seen before the sequencer starts waiting for sync is ignored, and a level that stays high does not trigger a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_set | input | 1 | Pulse: set the run flag |
| start_clr | input | 1 | Pulse: clear the run flag |
| soft_rst | input | 1 | Pulse: stop and re-arm at instruction 0 |
| start_flag | output | 1 | Current run flag |
| busy | output | 1 | Sequencer running status |
| instr_addr | output | 3 | Instruction store read address |
| instr_data | input | 9 | Control field of the addressed instruction (combinational read) |
| sync_pin | input | 1 | Asynchronous external conversion trigger |
| acq_start | output | 1 | Pulse: begin acquisition |
| acq_done | input | 1 | Pulse: acquisition finished |
| conv_start | output | 1 | Pulse: begin conversion |
| conv_done | input | 1 | Pulse: conversion finished |
| pos_ch | output | 3 | Non-inverting channel code |
| neg_ch | output | 3 | Inverting channel code |
| neg_gnd | output | 1 | Inverting input is ground |
| pause_irq | output | 1 | Single-cycle pause interrupt |

## Verification
The assertions check on every cycle that the handshake and interrupt pulses last one cycle, that a pause interrupt coincides with a cleared run flag and no acquisition, and that no conversion starts while waiting for sync without a synchronized edge. They also check that a stopped sequencer at a boundary stays quiet. The order of execution across loop flags and wrap-around, the skipped pause on the first pass, resuming after a pause, and the finish-then-stop behaviour can only be shown by the bench's scenarios against its cycle-accurate model.

// File: rtl/conv_seq_pkg.sv
// Shared definitions for the conversion sequencer: control word layout and
// the controller state encoding. Assumes a 9-bit control field per instruction.
package conv_seq_pkg;

    localparam int unsigned CH_W = 3;

    // Control word, packed so bit positions match the instruction store layout:
    // [8] sync, [7:5] negative channel, [4:2] positive channel, [1] pause, [0] loop
    typedef struct packed {
        logic            sync;
        logic [CH_W-1:0] neg;
        logic [CH_W-1:0] pos;
        logic            pause;
        logic            last;
    } ctl_word_t;

    localparam int unsigned CTL_W = $bits(ctl_word_t);

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_FETCH      = 3'd1,
        ST_WAIT_START = 3'd2,
        ST_ACQUIRE    = 3'd3,
        ST_WAIT_SYNC  = 3'd4,
        ST_CONVERT    = 3'd5,
        ST_NEXT       = 3'd6
    } seq_state_t;

endpackage

// File: rtl/seq_sync_edge.sv
// Brings an asynchronous pin into the clock domain through a flop chain and
// flags a rising edge of the synchronized level for one cycle.
// Assumes STAGES >= 2.
module seq_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the pin through the synchronizer and keep the last synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            prev  <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] & ~prev;

endmodule

// File: rtl/seq_run_flag.sv
// Holds the run (START) flag. A soft reset or a pause event clears it,
// and so does a host clear; a host set makes it 1. Earlier sources win.
module seq_run_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic pause_clr,
    input  logic clr_req,
    input  logic set_req,
    output logic run_flag
);

    // Update the flag by priority: soft reset, pause, host clear, host set.
    always_ff @(posedge clk) begin
        if (!rst_n)         run_flag <= 1'b0;
        else if (soft_rst)  run_flag <= 1'b0;
        else if (pause_clr) run_flag <= 1'b0;
        else if (clr_req)   run_flag <= 1'b0;
        else if (set_req)   run_flag <= 1'b1;
    end

endmodule

// File: rtl/seq_fsm.sv
// Instruction-stepping controller: reads and latches each control word, then
// sequences acquire, optional sync hold and convert. It also applies the
// loop/wrap rule and the pause rule with first-pass skip.
// Assumes a combinational instruction store read and single-cycle done pulses.
module seq_fsm
    import conv_seq_pkg::*;
#(
    parameter int unsigned NUM_INSTR = 8,
    localparam int unsigned PTR_W    = $clog2(NUM_INSTR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             run_flag,
    input  logic [CTL_W-1:0] instr_data,
    input  logic             sync_rise,
    input  logic             acq_done,
    input  logic             conv_done,
    output logic [PTR_W-1:0] instr_addr,
    output ctl_word_t        ctl,
    output seq_state_t       state,
    output logic             pause_now,
    output logic             acq_start,
    output logic             conv_start,
    output logic             pause_irq,
    output logic             busy
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_INSTR - 1);

    logic [PTR_W-1:0] ptr;
    logic             skip_pause;

    // A pause takes effect only when running, flagged, and not exempted.
    assign pause_now = (state == ST_WAIT_START) && run_flag && ctl.pause
                       && !skip_pause && !soft_rst;

    // Main controller: state, instruction pointer, latched word and pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            ptr        <= '0;
            ctl        <= '0;
            skip_pause <= 1'b1;
            acq_start  <= 1'b0;
            conv_start <= 1'b0;
            pause_irq  <= 1'b0;
        end else begin
            acq_start  <= 1'b0;
            conv_start <= 1'b0;
            pause_irq  <= 1'b0;
            if (soft_rst) begin
                state <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        ptr        <= '0;
                        skip_pause <= 1'b1;
                        state      <= ST_FETCH;
                    end
                    ST_FETCH: begin
                        ctl   <= ctl_word_t'(instr_data);
                        state <= ST_WAIT_START;
                    end
                    ST_WAIT_START: begin
                        if (pause_now) begin
                            pause_irq  <= 1'b1;
                            skip_pause <= 1'b1;
                        end else if (run_flag) begin
                            skip_pause <= 1'b0;
                            acq_start  <= 1'b1;
                            state      <= ST_ACQUIRE;
                        end
                    end
                    ST_ACQUIRE: begin
                        if (acq_done) begin
                            if (ctl.sync) begin
                                state <= ST_WAIT_SYNC;
                            end else begin
                                conv_start <= 1'b1;
                                state      <= ST_CONVERT;
                            end
                        end
                    end
                    ST_WAIT_SYNC: begin
                        if (sync_rise) begin
                            conv_start <= 1'b1;
                            state      <= ST_CONVERT;
                        end
                    end
                    ST_CONVERT: begin
                        if (conv_done) state <= ST_NEXT;
                    end
                    ST_NEXT: begin
                        ptr   <= (ctl.last || ptr == LAST_IDX) ? '0 : PTR_W'(ptr + 1'b1);
                        state <= ST_FETCH;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Running status: executing, or reading the next word of a running pass.
    always_comb begin
        unique case (state)
            ST_ACQUIRE, ST_WAIT_SYNC, ST_CONVERT, ST_NEXT: busy = 1'b1;
            ST_FETCH:                                       busy = !skip_pause;
            default:                                        busy = 1'b0;
        endcase
    end

    assign instr_addr = ptr;

endmodule

// File: rtl/conv_sequencer.sv
// Top of the conversion instruction sequencer: joins the run flag, the sync
// edge detector and the stepping controller, and exposes channel codes.
// Assumes host pulses are synchronous to clk; only sync_pin is asynchronous.
module conv_sequencer
    import conv_seq_pkg::*;
#(
    parameter int unsigned NUM_INSTR   = 8,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned PTR_W      = $clog2(NUM_INSTR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_set,
    input  logic             start_clr,
    input  logic             soft_rst,
    output logic             start_flag,
    output logic             busy,
    output logic [PTR_W-1:0] instr_addr,
    input  logic [CTL_W-1:0] instr_data,
    input  logic             sync_pin,
    output logic             acq_start,
    input  logic             acq_done,
    output logic             conv_start,
    input  logic             conv_done,
    output logic [CH_W-1:0]  pos_ch,
    output logic [CH_W-1:0]  neg_ch,
    output logic             neg_gnd,
    output logic             pause_irq
);

    logic       sync_rise;
    logic       pause_now;
    ctl_word_t  ctl;
    seq_state_t state;

    seq_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sync_pin),
        .rise     (sync_rise)
    );

    seq_run_flag u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .pause_clr (pause_now),
        .clr_req   (start_clr),
        .set_req   (start_set),
        .run_flag  (start_flag)
    );

    seq_fsm #(.NUM_INSTR(NUM_INSTR)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .run_flag   (start_flag),
        .instr_data (instr_data),
        .sync_rise  (sync_rise),
        .acq_done   (acq_done),
        .conv_done  (conv_done),
        .instr_addr (instr_addr),
        .ctl        (ctl),
        .state      (state),
        .pause_now  (pause_now),
        .acq_start  (acq_start),
        .conv_start (conv_start),
        .pause_irq  (pause_irq),
        .busy       (busy)
    );

    assign pos_ch  = ctl.pos;
    assign neg_ch  = ctl.neg;
    assign neg_gnd = (ctl.neg == '0);

endmodule

// File: rtl/conv_seq_chk.sv
// Property checker for conv_sequencer, attached by bind below.
module conv_seq_chk
    import conv_seq_pkg::*;
#(
    parameter int unsigned PTR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input seq_state_t       state,
    input logic             start_flag,
    input logic             busy,
    input logic [PTR_W-1:0] instr_addr,
    input logic             acq_start,
    input logic             conv_start,
    input logic             pause_irq,
    input logic             sync_rise
);

    a_r1_reset_home: assert property (@(posedge clk)
        !rst_n |=> (instr_addr == '0 && !busy && !start_flag && !acq_start));

    a_r2_acq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        acq_start |=> !acq_start);

    a_r5_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pause_irq |=> !pause_irq);

    a_r5_irq_stops: assert property (@(posedge clk) disable iff (!rst_n)
        pause_irq |-> (!start_flag && !acq_start));

    a_r7_sync_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_SYNC && !sync_rise) |=> !conv_start);

    a_r8_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_START && !start_flag) |=> !acq_start);

    a_r9_busy_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_start || conv_start) |-> busy);

endmodule

bind conv_sequencer conv_seq_chk #(.PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .start_flag (start_flag),
    .busy       (busy),
    .instr_addr (instr_addr),
    .acq_start  (acq_start),
    .conv_start (conv_start),
    .pause_irq  (pause_irq),
    .sync_rise  (sync_rise)
);

// File: tb/tb_conv_sequencer.sv
module tb_conv_sequencer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_set = 1'b0, start_clr = 1'b0, soft_rst = 1'b0;
    logic       sync_pin = 1'b0, acq_done = 1'b0, conv_done = 1'b0;
    logic       start_flag, busy, acq_start, conv_start, neg_gnd, pause_irq;
    logic [2:0] instr_addr, pos_ch, neg_ch;
    logic [8:0] instr_data;
    logic [8:0] mem [8];

    int checks = 0, fails = 0, cycles = 0;
    int conv_cnt = 0, irq_cnt = 0;
    int exec_q[$];
    int pos_q[$];
    int neg_q[$];

    always #5 clk = ~clk;

    assign instr_data = mem[instr_addr];

    conv_sequencer dut (
        .clk(clk), .rst_n(rst_n), .start_set(start_set), .start_clr(start_clr),
        .soft_rst(soft_rst), .start_flag(start_flag), .busy(busy),
        .instr_addr(instr_addr), .instr_data(instr_data), .sync_pin(sync_pin),
        .acq_start(acq_start), .acq_done(acq_done), .conv_start(conv_start),
        .conv_done(conv_done), .pos_ch(pos_ch), .neg_ch(neg_ch),
        .neg_gnd(neg_gnd), .pause_irq(pause_irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    localparam int M_IDLE = 0, M_FETCH = 1, M_WS = 2, M_ACQ = 3, M_SYNC = 4, M_CONV = 5, M_NEXT = 6;
    int       ms;
    int       mptr;
    bit [8:0] mir;
    bit       mskip, mrun, macq, mconv, mirq;
    bit [2:0] sy;

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = M_IDLE; mptr = 0; mir = 0; mskip = 1; mrun = 0;
            macq = 0; mconv = 0; mirq = 0; sy = 0;
        end else begin
            bit rise, pnow, nrun;
            rise = sy[1] && !sy[2];
            pnow = (ms == M_WS) && mrun && mir[1] && !mskip && !soft_rst;
            if (soft_rst || pnow || start_clr) nrun = 0;
            else if (start_set) nrun = 1;
            else nrun = mrun;
            macq = 0; mconv = 0; mirq = 0;
            if (soft_rst) ms = M_IDLE;
            else begin
                case (ms)
                    M_IDLE:  begin mptr = 0; mskip = 1; ms = M_FETCH; end
                    M_FETCH: begin mir = mem[mptr]; ms = M_WS; end
                    M_WS: begin
                        if (pnow) begin mirq = 1; mskip = 1; end
                        else if (mrun) begin mskip = 0; macq = 1; ms = M_ACQ; end
                    end
                    M_ACQ: if (acq_done) begin
                        if (mir[8]) ms = M_SYNC;
                        else begin mconv = 1; ms = M_CONV; end
                    end
                    M_SYNC: if (rise) begin mconv = 1; ms = M_CONV; end
                    M_CONV: if (conv_done) ms = M_NEXT;
                    default: begin
                        mptr = (mir[0] || mptr == 7) ? 0 : mptr + 1;
                        ms = M_FETCH;
                    end
                endcase
            end
            mrun = nrun;
            sy = {sy[1:0], sync_pin};
        end
    end

    // Per-cycle comparison against the model, plus event recording.
    always @(negedge clk) begin
        cycles++;
        if (rst_n && cycles > 2) begin
            bit mbusy;
            mbusy = (ms >= M_ACQ) || (ms == M_FETCH && !mskip);
            check(instr_addr == mptr[2:0], "R3/R4 instr_addr", instr_addr, mptr);
            check(acq_start == macq, "R2 acq_start", acq_start, macq);
            check(conv_start == mconv, "R7 conv_start", conv_start, mconv);
            check(pause_irq == mirq, "R5 pause_irq", pause_irq, mirq);
            check(start_flag == mrun, "R8 start_flag", start_flag, mrun);
            check(busy == mbusy, "R9 busy", busy, mbusy);
            check(pos_ch == mir[4:2] && neg_ch == mir[7:5], "R6 channels",
                  {pos_ch, neg_ch}, {mir[4:2], mir[7:5]});
            check(neg_gnd == (mir[7:5] == 0), "R6 neg_gnd", neg_gnd, mir[7:5] == 0);
        end
        if (acq_start) begin
            exec_q.push_back(instr_addr);
            pos_q.push_back(pos_ch);
            neg_q.push_back({neg_gnd, neg_ch});
        end
        if (conv_start) conv_cnt++;
        if (pause_irq) irq_cnt++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Converter responder: done pulses a fixed delay after each request.
    initial begin
        int acnt = 0, ccnt = 0;
        forever begin
            @(negedge clk);
            acq_done = 0; conv_done = 0;
            if (acnt > 0) begin acnt--; if (acnt == 0) acq_done = 1; end
            if (ccnt > 0) begin ccnt--; if (ccnt == 0) conv_done = 1; end
            if (acq_start) acnt = 3;
            if (conv_start) ccnt = 3;
        end
    end

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) soft_rst = 1; else if (which == 1) start_set = 1; else start_clr = 1;
        @(negedge clk);
        soft_rst = 0; start_set = 0; start_clr = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_exec(input int n);
        for (int i = 0; i < 3000 && exec_q.size() < n; i++) @(negedge clk);
        check(exec_q.size() >= n, "wait exec", exec_q.size(), n);
    endtask

    task automatic wait_irq(input int n);
        for (int i = 0; i < 3000 && irq_cnt < n; i++) @(negedge clk);
        check(irq_cnt >= n, "R5 irq reached", irq_cnt, n);
    endtask

    task automatic load_clear();
        for (int i = 0; i < 8; i++) mem[i] = 9'd0;
    endtask

    initial begin
        load_clear();
        idle(3);
        rst_n = 1;
        idle(4);
        // R1: reset state
        check(instr_addr == 0, "R1 addr", instr_addr, 0);
        check(!busy && !start_flag, "R1 stopped", {busy, start_flag}, 0);
        idle(10);
        check(exec_q.size() == 0, "R1 no acq", exec_q.size(), 0);

        // Scenario A: pause on 0, loop on 2 (R2, R3, R5, R6)
        mem[0] = 9'd6;    // pause, pos 1, neg ground
        mem[1] = 9'd168;  // pos 2, neg 5
        mem[2] = 9'd29;   // loop, pos 7
        pulse(0);
        idle(3);
        pulse(1);
        wait_irq(1);
        idle(4);
        check(exec_q.size() == 3, "R2 first pass count", exec_q.size(), 3);
        check(exec_q[0] == 0 && exec_q[1] == 1 && exec_q[2] == 2, "R3 order",
              exec_q[2], 2);
        check(!start_flag && !busy, "R5 halted", {start_flag, busy}, 0);
        check(instr_addr == 0, "R5 halted at 0", instr_addr, 0);
        check(pos_q[1] == 2 && neg_q[1] == 5, "R6 instr1 channels", neg_q[1], 5);
        check(neg_q[0] == 8, "R6 ground on instr0", neg_q[0], 8);
        pulse(1);
        wait_irq(2);
        idle(4);
        check(exec_q.size() == 6 && exec_q[3] == 0, "R5 resume same instr",
              exec_q.size(), 6);
        check(irq_cnt == 2, "R5 irq count", irq_cnt, 2);

        // Scenario B: full wrap, then stop mid-instruction (R4, R8)
        load_clear();
        for (int i = 0; i < 8; i++) mem[i] = 9'(i << 2);
        exec_q.delete();
        pulse(0);
        idle(3);
        pulse(1);
        wait_exec(10);
        pulse(2);
        idle(40);
        check(exec_q.size() == 10, "R8 stop count", exec_q.size(), 10);
        check(exec_q[7] == 7 && exec_q[8] == 0, "R4 wrap", exec_q[8], 0);
        check(instr_addr == 2 && !busy, "R8 stopped at boundary", instr_addr, 2);
        check(conv_cnt == 16, "R8 last conversion done", conv_cnt, 16);

        // Scenario C: sync hold (R7, R10)
        load_clear();
        mem[0] = 9'd369;  // sync, neg 3, pos 4, loop
        exec_q.delete();
        pulse(0);
        idle(3);
        pulse(1);
        wait_exec(1);
        sync_pin = 1;     // edge during acquisition
        idle(25);
        check(conv_cnt == 16, "R10 early edge ignored", conv_cnt, 16);
        check(busy, "R7 waiting for sync", busy, 1);
        sync_pin = 0;
        idle(5);
        check(conv_cnt == 16, "R10 falling edge ignored", conv_cnt, 16);
        sync_pin = 1;
        pulse(2);
        idle(30);
        check(conv_cnt == 17, "R7 converted after edge", conv_cnt, 17);
        check(exec_q.size() == 1 && !busy, "R8 stop after sync conversion",
              exec_q.size(), 1);
        sync_pin = 0;

        // R1: soft reset mid-run
        pulse(1);
        wait_exec(2);
        pulse(0);
        idle(5);
        check(instr_addr == 0 && !busy && !start_flag, "R1 soft reset",
              {instr_addr, busy, start_flag}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule